// File: doc/BRIEF.md
# Event Counter Unit

This block is a bank of eight programmable event counters behind a 32-bit register interface. An event vector of 256 single-cycle pulses is presented to the unit. Each counter picks one of these lines through an 8-bit selection code. Software configures the unit by writing registers. It reads counter values and status back through a combinational read port. It can also preload any counter with a chosen value.

A counter advances only when three conditions hold: the global run bit is set, the counter's own enable bit is set, and the line its code selects is high on that clock edge. When a counter rolls over from all ones to zero, it sets a sticky overflow flag. Software clears the flag by writing a one to it. An interrupt line is raised for any flag that is not masked. The counter width is a build parameter of 48 or 64 bits, and a read-only revision register reports which width was built.

Top module: `evt_counter_unit`

## Requirements
- R1: After reset the control register (0x0408) reads 0, the mask register (0x0800) reads 0xFF, status (0x0808) reads 0, the enable register (0x1C00) reads 0, both selection registers (0x1D00, 0x1D04) read 0xFFFFFFFF, every counter word reads 0, and irq is low.
- R2: Counter n adds one on each rising edge at which its selected event line is high, bit 16 of 0x0408 is 1, and bit n of 0x1C00 is 1.
- R3: While bit 16 of 0x0408 is 0, no counter changes except through a register write.
- R4: While bit n of 0x1C00 is 0, counter n does not change except through a register write.
- R5: A selection code of 0xFF selects no event: the counter stays unchanged even when event line 255 is high.
- R6: The selection code for counter n is bits [8*(n mod 4)+7 : 8*(n mod 4)] of 0x1D00 for n < 4, and of 0x1D04 for n >= 4. These registers read back as written.
- R7: Counter n has its low word at 0x1E00 + 8n and its high word at 0x1E04 + 8n. A write to either word is visible from the next edge. On that edge the write replaces any increment.
- R8: In a 48-bit build, bits 31:16 of every high counter word read as 0, and writes to those bits are ignored.
- R9: When counter n increments from all ones, it becomes 0 and status bit n (0x0808) is set on the same edge. The bit stays set until it is cleared.
- R10: Writing 1 to bit n of 0x080C clears status bit n. Writing 0 there leaves the status unchanged.
- R11: irq is high exactly when some status bit n is set while mask bit n (0x0800) is 0. A mask bit of 1 blocks that counter's interrupt.
- R12: The register at 0x1CF0 reads 0x00000100 in a 48-bit build and 0x00000200 in a 64-bit build, and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 16 | Register read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_in | input | 256 | Event pulse lines, indexed by selection code |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check the following on every cycle:
- A cleared run bit or enable bit freezes the counters.
- A rollover always leaves its status flag set.
- A write-one-to-clear removes a flag unless a rollover coincides.
- Masking every counter drops the interrupt.
- The upper half of a narrow counter's high word never shows a one.

Other behaviour is shown only by the bench's scenarios:
- An increment lands on the correct counter through the packed selection fields.
- The 0xFF code is treated as no event.
- A preload takes precedence over an increment.
- The interrupt depends on the mask value.

// File: rtl/evcu_pkg.sv
package evcu_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int RUN_BIT = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 16'h0408;
  localparam logic [ADDR_W-1:0] A_MASK = 16'h0800;
  localparam logic [ADDR_W-1:0] A_STAT = 16'h0808;
  localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_ENA  = 16'h1C00;
  localparam logic [ADDR_W-1:0] A_VER  = 16'h1CF0;
  localparam logic [ADDR_W-1:0] A_SEL0 = 16'h1D00;
  localparam logic [ADDR_W-1:0] A_CTR0 = 16'h1E00;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_wr_t;
endpackage

// File: rtl/evcu_regs.sv
module evcu_regs
  import evcu_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int SEL_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bus_wr_t                  wr,
  input  logic [NUM_CTR-1:0]       wrap,
  output logic                     run,
  output logic [NUM_CTR-1:0]       en,
  output logic [NUM_CTR-1:0]       mask,
  output logic [NUM_CTR-1:0]       status,
  output logic [NUM_CTR*SEL_W-1:0] sel_flat
);
  localparam int PER_REG = DATA_W / SEL_W;
  localparam int NSEL    = (NUM_CTR + PER_REG - 1) / PER_REG;

  logic                     run_q, run_d;
  logic [NUM_CTR-1:0]       en_q, en_d, mask_q, mask_d, stat_q, stat_d;
  logic [NUM_CTR*SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    run_d  = run_q;
    en_d   = en_q;
    mask_d = mask_q;
    stat_d = stat_q;
    sel_d  = sel_q;
    if (wr.we) begin
      if (wr.addr == A_CTRL) run_d  = wr.data[RUN_BIT];
      if (wr.addr == A_ENA)  en_d   = wr.data[NUM_CTR-1:0];
      if (wr.addr == A_MASK) mask_d = wr.data[NUM_CTR-1:0];
      if (wr.addr == A_CLR)  stat_d = stat_q & ~wr.data[NUM_CTR-1:0];
      for (int r = 0; r < NSEL; r++) begin
        if (wr.addr == A_SEL0 + ADDR_W'(4 * r)) begin
          for (int k = 0; k < PER_REG; k++) begin
            if (r * PER_REG + k < NUM_CTR)
              sel_d[(r*PER_REG+k)*SEL_W +: SEL_W] = wr.data[k*SEL_W +: SEL_W];
          end
        end
      end
    end
    stat_d = stat_d | wrap;  // a rollover wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      stat_q <= '0;
      sel_q  <= '1;
    end else begin
      run_q  <= run_d;
      en_q   <= en_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      sel_q  <= sel_d;
    end
  end

  assign run      = run_q;
  assign en       = en_q;
  assign mask     = mask_q;
  assign status   = stat_q;
  assign sel_flat = sel_q;
endmodule

// File: rtl/evcu_counter.sv
module evcu_counter
  import evcu_pkg::*;
#(
  parameter int CTR_W = 48,
  parameter int SEL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2**SEL_W-1:0]   evt_vec,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  cnt_en,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [DATA_W-1:0]     wdata,
  output logic [63:0]           value,
  output logic                  wrap
);
  localparam logic [SEL_W-1:0] SEL_NONE = '1;
  localparam int HI_W = CTR_W - DATA_W;

  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit = cnt_en && (sel != SEL_NONE) && evt_vec[sel];

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[DATA_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CTR_W-1:DATA_W] = wdata[HI_W-1:0];
    end else if (hit) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value = 64'(cnt_q);
endmodule

// File: rtl/evcu_rdmux.sv
module evcu_rdmux
  import evcu_pkg::*;
#(
  parameter int          NUM_CTR = 8,
  parameter int          SEL_W   = 8,
  parameter logic [31:0] VER_ID  = 32'h100
) (
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     run,
  input  logic [NUM_CTR-1:0]       en,
  input  logic [NUM_CTR-1:0]       mask,
  input  logic [NUM_CTR-1:0]       status,
  input  logic [NUM_CTR*SEL_W-1:0] sel_flat,
  input  logic [NUM_CTR*64-1:0]    ctr_flat,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int PER_REG = DATA_W / SEL_W;
  localparam int NSEL    = (NUM_CTR + PER_REG - 1) / PER_REG;

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data[RUN_BIT]     = run;
    if (rd_addr == A_ENA)  rd_data[NUM_CTR-1:0] = en;
    if (rd_addr == A_MASK) rd_data[NUM_CTR-1:0] = mask;
    if (rd_addr == A_STAT) rd_data[NUM_CTR-1:0] = status;
    if (rd_addr == A_VER)  rd_data              = VER_ID;
    for (int r = 0; r < NSEL; r++) begin
      if (rd_addr == A_SEL0 + ADDR_W'(4 * r)) begin
        for (int k = 0; k < PER_REG; k++) begin
          if (r * PER_REG + k < NUM_CTR)
            rd_data[k*SEL_W +: SEL_W] = sel_flat[(r*PER_REG+k)*SEL_W +: SEL_W];
        end
      end
    end
    for (int n = 0; n < NUM_CTR; n++) begin
      if (rd_addr == A_CTR0 + ADDR_W'(8 * n))     rd_data = ctr_flat[n*64 +: 32];
      if (rd_addr == A_CTR0 + ADDR_W'(8 * n + 4)) rd_data = ctr_flat[n*64+32 +: 32];
    end
  end
endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit
  import evcu_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 48,
  parameter int SEL_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [15:0]          wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [15:0]          rd_addr,
  output logic [31:0]          rd_data,
  input  logic [2**SEL_W-1:0]  evt_in,
  output logic                 irq
);
  localparam logic [31:0] VER_ID = (CTR_W == 64) ? 32'h0000_0200 : 32'h0000_0100;

  bus_wr_t                  wr_bus;
  logic                     run_q;
  logic [NUM_CTR-1:0]       en_q, mask_q, status_q, wrap_vec;
  logic [NUM_CTR*SEL_W-1:0] sel_flat;
  logic [NUM_CTR*64-1:0]    ctr_flat;

  assign wr_bus = '{we: wr_en, addr: wr_addr, data: wr_data};

  evcu_regs #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr_bus), .wrap(wrap_vec),
    .run(run_q), .en(en_q), .mask(mask_q), .status(status_q),
    .sel_flat(sel_flat)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en && (wr_addr == A_CTR0 + ADDR_W'(8 * n));
    assign wr_hi = wr_en && (wr_addr == A_CTR0 + ADDR_W'(8 * n + 4));
    evcu_counter #(.CTR_W(CTR_W), .SEL_W(SEL_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .evt_vec(evt_in),
      .sel(sel_flat[n*SEL_W +: SEL_W]),
      .cnt_en(run_q && en_q[n]),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wr_data),
      .value(ctr_flat[n*64 +: 64]), .wrap(wrap_vec[n])
    );
  end

  evcu_rdmux #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W), .VER_ID(VER_ID)) u_rdmux (
    .rd_addr(rd_addr), .run(run_q), .en(en_q), .mask(mask_q),
    .status(status_q), .sel_flat(sel_flat), .ctr_flat(ctr_flat),
    .rd_data(rd_data)
  );

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/evcu_chk.sv
module evcu_chk
  import evcu_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 48
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [15:0]           wr_addr,
  input logic [31:0]           wr_data,
  input logic [15:0]           rd_addr,
  input logic [31:0]           rd_data,
  input logic                  irq,
  input logic                  run_q,
  input logic [NUM_CTR-1:0]    en_q,
  input logic [NUM_CTR-1:0]    status_q,
  input logic [NUM_CTR-1:0]    wrap_vec,
  input logic [NUM_CTR*64-1:0] ctr_flat
);
  logic any_ctr_wr;
  assign any_ctr_wr = wr_en && (wr_addr >= A_CTR0) &&
                      (wr_addr < A_CTR0 + ADDR_W'(8 * NUM_CTR));

  // R3
  run_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !any_ctr_wr) |=> $stable(ctr_flat));

  // R11
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK && (&wr_data[NUM_CTR-1:0])) |=> !irq);

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
    logic slot_wr;
    assign slot_wr = wr_en && ((wr_addr == A_CTR0 + ADDR_W'(8 * n)) ||
                               (wr_addr == A_CTR0 + ADDR_W'(8 * n + 4)));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[n] && !slot_wr) |=> $stable(ctr_flat[n*64 +: 64]));

    // R9
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[n] |=> status_q[n]);

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CLR && wr_data[n] && !wrap_vec[n]) |=> !status_q[n]);

    if (CTR_W < 64) begin : g_narrow
      // R8
      hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CTR0 + ADDR_W'(8 * n + 4)) |-> ((rd_data >> (CTR_W - 32)) == 32'd0));
    end
  end
endmodule

bind evt_counter_unit evcu_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
  .run_q(run_q), .en_q(en_q), .status_q(status_q), .wrap_vec(wrap_vec),
  .ctr_flat(ctr_flat)
);

// File: tb/evt_counter_unit_tb.sv
module evt_counter_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [255:0] evt_in = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_counter_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .irq(irq)
  );

  // counter, code, pulses, expected count
  typedef struct packed {
    logic [2:0]  ctr;
    logic [7:0]  code;
    logic [7:0]  pulses;
    logic [31:0] exp_cnt;
  } row_t;
  localparam int NROWS = 6;
  localparam row_t TABLE [NROWS] = '{
    '{3'd0, 8'h00, 8'd5, 32'd5},
    '{3'd3, 8'h10, 8'd7, 32'd7},
    '{3'd4, 8'h48, 8'd3, 32'd3},
    '{3'd7, 8'h7F, 8'd9, 32'd9},
    '{3'd5, 8'hFF, 8'd6, 32'd0},
    '{3'd1, 8'hB8, 8'd1, 32'd1}
  };

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string req);
    @(negedge clk);
    #1;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic pulse(input int code, input int n);
    @(negedge clk);
    evt_in[code] = 1'b1;
    evt_in[255]  = 1'b1;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(16'h0408, 32'h0, "R1");
    rd_chk(16'h0800, 32'hFF, "R1");
    rd_chk(16'h0808, 32'h0, "R1");
    rd_chk(16'h1C00, 32'h0, "R1");
    rd_chk(16'h1D00, 32'hFFFF_FFFF, "R1");
    rd_chk(16'h1D04, 32'hFFFF_FFFF, "R1");
    rd_chk(16'h1E00, 32'h0, "R1");
    rd_chk(16'h1E3C, 32'h0, "R1");
    irq_chk(1'b0, "R1");

    // R12 version
    rd_chk(16'h1CF0, 32'h100, "R12");
    wr(16'h1CF0, 32'hDEAD_BEEF);
    rd_chk(16'h1CF0, 32'h100, "R12");

    // R2 R5 R6 table walk
    for (int i = 0; i < NROWS; i++) begin
      logic [31:0] selv;
      int c;
      c = int'(TABLE[i].ctr);
      selv = 32'hFFFF_FFFF;
      selv[(c % 4)*8 +: 8] = TABLE[i].code;
      wr(16'h1D00, 32'hFFFF_FFFF);
      wr(16'h1D04, 32'hFFFF_FFFF);
      wr(16'h1D00 + 16'((c / 4) * 4), selv);
      rd_chk(16'h1D00 + 16'((c / 4) * 4), selv, "R6");
      wr(16'h1E00 + 16'(8 * c), 32'h0);
      wr(16'h1C00, 32'(1) << c);
      wr(16'h0408, 32'h0001_0000);
      pulse(int'(TABLE[i].code), int'(TABLE[i].pulses));
      wr(16'h0408, 32'h0);
      rd_chk(16'h1E00 + 16'(8 * c), TABLE[i].exp_cnt, (TABLE[i].code == 8'hFF) ? "R5" : "R2");
    end

    // R4 enable off holds counter 2
    wr(16'h1D00, 32'hFF05_FFFF);
    wr(16'h1E10, 32'h0);
    wr(16'h1C00, 32'h0);
    wr(16'h0408, 32'h0001_0000);
    pulse(5, 4);
    rd_chk(16'h1E10, 32'h0, "R4");

    // R3 run bit off freezes
    wr(16'h1C00, 32'h04);
    wr(16'h0408, 32'h0);
    pulse(5, 4);
    rd_chk(16'h1E10, 32'h0, "R3");
    wr(16'h0408, 32'h0001_0000);
    pulse(5, 2);
    rd_chk(16'h1E10, 32'h2, "R3");

    // R7 write overrides a same-edge increment
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h1E10; wr_data = 32'd100; evt_in[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_in = '0;
    rd_chk(16'h1E10, 32'd100, "R7");

    // R8 narrow high word
    wr(16'h1E14, 32'hFFFF_FFFF);
    rd_chk(16'h1E14, 32'h0000_FFFF, "R8");

    // R9 rollover, R11 masking
    wr(16'h1E10, 32'hFFFF_FFFF);
    pulse(5, 1);
    rd_chk(16'h1E10, 32'h0, "R9");
    rd_chk(16'h1E14, 32'h0, "R9");
    rd_chk(16'h0808, 32'h04, "R9");
    irq_chk(1'b0, "R11");
    wr(16'h0800, 32'hFB);
    irq_chk(1'b1, "R11");

    // R10 write-one-to-clear
    wr(16'h080C, 32'h0);
    rd_chk(16'h0808, 32'h04, "R10");
    wr(16'h080C, 32'h04);
    rd_chk(16'h0808, 32'h0, "R10");
    irq_chk(1'b0, "R11");

    finish_run();
  end
endmodule